// File: doc/BRIEF.md
# Multiply-Accumulate and Divide Unit

This unit holds the two 32-bit result registers HI and LO of a small RISC core and performs every operation that writes them. A one-cycle `start` strobe carries a 4-bit operation code and two 32-bit operands. Multiplies, signed or unsigned, finish in one cycle and leave a 64-bit product split across HI (upper word) and LO (lower word). The multiply-add forms add the 32x32 product to the current 64-bit HI:LO value in that same single cycle.

Divides, signed or unsigned, run through a restoring radix-2 loop that retires one quotient bit per cycle. They finish with the quotient in LO and the remainder in HI. While a divide is in progress `busy` stays high.

Software moves words into HI or LO with move-to operations and reads them back with move-from operations. A move-from that arrives during a divide is held and answered in the cycle the divide completes. Any other operation that arrives while busy is dropped and flagged with a one-cycle error pulse.

Top module: `mdu_unit`

## Requirements
- R1: Operation codes 0 (signed multiply) and 1 (unsigned multiply) write the 64-bit product of `opA` and `opB`, with the upper 32 bits to HI and the lower 32 bits to LO.
- R2: Operation codes 2 (signed) and 3 (unsigned) write HI:LO plus the product of `opA` and `opB`, wrapped to 64 bits. The result is readable by a move-from issued in the very next cycle, and `busy` never rises.
- R3: Operation codes 4 (signed) and 5 (unsigned) divide `opA` by `opB`, with the quotient to LO and the remainder to HI. A signed quotient truncates toward zero, and a signed remainder takes the sign of the dividend.
- R4: A divide with `opB` equal to zero writes all ones to LO and the unmodified `opA` to HI, in both the signed and the unsigned form.
- R5: After the clock edge that accepts a divide, `busy` reads high for exactly 32 cycles, and the new HI and LO values are in place when it falls.
- R6: Operation code 6 copies `opA` into HI and code 7 copies `opA` into LO. Code 8 reads HI and code 9 reads LO: one cycle after acceptance `rdValid` is high for one cycle with the register value on `rdData`.
- R7: A move-from (code 8 or 9) started while `busy` is high raises no `rdValid` until the divide ends. In the cycle that `busy` reads low again, `rdValid` is high and `rdData` holds the completed divide's value.
- R8: A start of codes 0 to 7 while `busy` is high, or a second move-from while one is already held, is ignored and raises `err` for exactly one cycle. HI and LO keep the divide's result.
- R9: While reset is asserted, and after it is released, `busy`, `rdValid` and `err` are low, and HI and LO read as zero.
- R10: Operation codes 10 to 15 change neither HI nor LO and raise neither `rdValid` nor `err`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Operation strobe, one cycle per operation |
| op | input | 4 | Operation code (see requirements) |
| opA | input | 32 | First operand, dividend, or word to move |
| opB | input | 32 | Second operand or divisor |
| busy | output | 1 | Divide in progress |
| err | output | 1 | One-cycle pulse for a rejected start |
| rdValid | output | 1 | Move-from result valid |
| rdData | output | 32 | Move-from result |

## Verification
The embedded properties watch, on every cycle, that HI and LO stay frozen while a divide iterates and that `busy` cannot drop before the last quotient bit. They also check that a read result never appears while busy, that a multiply-add never raises busy, and that an error pulse only follows a busy cycle. The arithmetic values cannot be checked that way. Signs, truncation toward zero, the divide-by-zero pattern and the wrap of the 64-bit accumulate are compared against a reference model over the stimulus table. The directed scenarios cover the exact 32-cycle busy window, the held read answered at completion, the rejected starts, and the undefined codes.

// File: rtl/mdu_pkg.sv
package mdu_pkg;
  typedef enum logic [3:0] {
    OP_MULT  = 4'd0,
    OP_MULTU = 4'd1,
    OP_MADD  = 4'd2,
    OP_MADDU = 4'd3,
    OP_DIV   = 4'd4,
    OP_DIVU  = 4'd5,
    OP_MTHI  = 4'd6,
    OP_MTLO  = 4'd7,
    OP_MFHI  = 4'd8,
    OP_MFLO  = 4'd9
  } mduOp_e;

  // strobes from control to datapath
  typedef struct packed {
    logic mulEn;
    logic maddEn;
    logic isSigned;
    logic divLoad;
    logic divStep;
    logic divLast;
    logic wrHi;
    logic wrLo;
    logic rdEn;
    logic rdSelLo;
  } mduCtl_t;
endpackage

// File: rtl/mdu_ctrl.sv
module mdu_ctrl
  import mdu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  input  logic [3:0] op,
  output mduCtl_t ctl,
  output logic    busy,
  output logic    err
);
  localparam int CNT_W = $clog2(WIDTH);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WIDTH - 1);

  logic busyQ, pendQ, pendSelQ, errQ;
  logic [CNT_W-1:0] cntQ;
  logic isMf, isWork, accept, newPend, errNext;

  always_comb begin
    isMf    = (op == OP_MFHI) || (op == OP_MFLO);
    isWork  = (op <= OP_MTLO);
    accept  = start && !busyQ;
    newPend = start && busyQ && isMf && !pendQ;
    errNext = start && busyQ && (isWork || (isMf && pendQ));

    ctl          = '0;
    ctl.isSigned = !op[0];
    ctl.mulEn    = accept && ((op == OP_MULT) || (op == OP_MULTU));
    ctl.maddEn   = accept && ((op == OP_MADD) || (op == OP_MADDU));
    ctl.divLoad  = accept && ((op == OP_DIV) || (op == OP_DIVU));
    ctl.divStep  = busyQ;
    ctl.divLast  = busyQ && (cntQ == LAST);
    ctl.wrHi     = accept && (op == OP_MTHI);
    ctl.wrLo     = accept && (op == OP_MTLO);
    ctl.rdEn     = (accept && isMf) || (ctl.divLast && (pendQ || newPend));
    ctl.rdSelLo  = pendQ ? pendSelQ : (op == OP_MFLO);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ    <= 1'b0;
      cntQ     <= '0;
      pendQ    <= 1'b0;
      pendSelQ <= 1'b0;
      errQ     <= 1'b0;
    end else begin
      errQ <= errNext;
      if (ctl.divLoad) begin
        busyQ <= 1'b1;
        cntQ  <= '0;
      end else if (ctl.divLast) begin
        busyQ <= 1'b0;
      end else if (busyQ) begin
        cntQ <= cntQ + 1'b1;
      end
      if (ctl.divLast)  pendQ <= 1'b0;
      else if (newPend) pendQ <= 1'b1;
      if (newPend) pendSelQ <= (op == OP_MFLO);
    end
  end

  assign busy = busyQ;
  assign err  = errQ;

  // R5: busy is only entered from an accepted start
  p_busy_from_start_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busyQ) |-> $past(start));
  // R5: busy cannot end before the final iteration
  p_busy_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (busyQ && (cntQ != LAST)) |=> busyQ);
  // R8: an error pulse only follows a busy cycle
  p_err_after_busy_r8: assert property (@(posedge clk) disable iff (!rstN)
    errQ |-> $past(busyQ));
endmodule

// File: rtl/mdu_datapath.sv
module mdu_datapath
  import mdu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  mduCtl_t          ctl,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  output logic [WIDTH-1:0] rdData,
  output logic             rdValid
);
  localparam int DW = 2 * WIDTH;

  logic [WIDTH-1:0] hiQ, loQ, remQ, quoQ, dvsQ, dividendQ;
  logic negQuoQ, negRemQ, zeroQ;

  logic [DW-1:0]    extA, extB, prod, macc;
  logic [WIDTH:0]   trial;
  logic [WIDTH-1:0] remN, quoN, qFin, rFin, absA, absB, hiNext, loNext;

  // multiply and multiply-add
  always_comb begin
    extA = {{WIDTH{ctl.isSigned & opA[WIDTH-1]}}, opA};
    extB = {{WIDTH{ctl.isSigned & opB[WIDTH-1]}}, opB};
    prod = extA * extB;
    macc = {hiQ, loQ} + prod;
  end

  // one restoring divide step plus final sign fix
  always_comb begin
    trial = {remQ, quoQ[WIDTH-1]} - {1'b0, dvsQ};
    if (!trial[WIDTH]) begin
      remN = trial[WIDTH-1:0];
      quoN = {quoQ[WIDTH-2:0], 1'b1};
    end else begin
      remN = {remQ[WIDTH-2:0], quoQ[WIDTH-1]};
      quoN = {quoQ[WIDTH-2:0], 1'b0};
    end
    qFin = zeroQ ? '1 : (negQuoQ ? -quoN : quoN);
    rFin = zeroQ ? dividendQ : (negRemQ ? -remN : remN);
    absA = (ctl.isSigned && opA[WIDTH-1]) ? -opA : opA;
    absB = (ctl.isSigned && opB[WIDTH-1]) ? -opB : opB;
  end

  always_comb begin
    hiNext = hiQ;
    loNext = loQ;
    if (ctl.mulEn) {hiNext, loNext} = prod;
    if (ctl.maddEn) {hiNext, loNext} = macc;
    if (ctl.divLast) begin
      hiNext = rFin;
      loNext = qFin;
    end
    if (ctl.wrHi) hiNext = opA;
    if (ctl.wrLo) loNext = opA;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hiQ       <= '0;
      loQ       <= '0;
      remQ      <= '0;
      quoQ      <= '0;
      dvsQ      <= '0;
      dividendQ <= '0;
      negQuoQ   <= 1'b0;
      negRemQ   <= 1'b0;
      zeroQ     <= 1'b0;
      rdData    <= '0;
      rdValid   <= 1'b0;
    end else begin
      hiQ     <= hiNext;
      loQ     <= loNext;
      rdValid <= ctl.rdEn;
      if (ctl.rdEn) rdData <= ctl.rdSelLo ? loNext : hiNext;
      if (ctl.divLoad) begin
        remQ      <= '0;
        quoQ      <= absA;
        dvsQ      <= absB;
        dividendQ <= opA;
        negQuoQ   <= ctl.isSigned && (opA[WIDTH-1] ^ opB[WIDTH-1]);
        negRemQ   <= ctl.isSigned && opA[WIDTH-1];
        zeroQ     <= (opB == '0);
      end else if (ctl.divStep) begin
        remQ <= remN;
        quoQ <= quoN;
      end
    end
  end

  // R8: HI and LO are frozen while the divider iterates
  p_hilo_frozen_r8: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.divStep && !ctl.divLast) |=> ($stable(hiQ) && $stable(loQ)));
  // R4: a zero divisor ends with an all-ones quotient
  p_zero_divisor_r4: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.divLast && zeroQ) |=> (loQ == '1));
endmodule

// File: rtl/mdu_unit.sv
module mdu_unit
  import mdu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [3:0]       op,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  output logic             busy,
  output logic             err,
  output logic             rdValid,
  output logic [WIDTH-1:0] rdData
);
  mduCtl_t ctl;

  mdu_ctrl #(.WIDTH(WIDTH)) uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .op(op),
    .ctl(ctl), .busy(busy), .err(err)
  );

  mdu_datapath #(.WIDTH(WIDTH)) uPath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .opA(opA), .opB(opB),
    .rdData(rdData), .rdValid(rdValid)
  );

  // R7: no read result is delivered while a divide is running
  p_read_when_idle_r7: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> !busy);
  // R2: an accepted multiply-add never raises busy
  p_madd_no_busy_r2: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy && ((op == OP_MADD) || (op == OP_MADDU))) |=> !busy);
endmodule

// File: tb/mdu_unit_test.sv
module mdu_unit_test;
  import mdu_pkg::*;

  typedef struct packed {
    logic [3:0]  op;
    logic [31:0] ih;
    logic [31:0] il;
    logic [31:0] a;
    logic [31:0] b;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{4'd0, 32'h0, 32'h0, 32'd3, 32'hFFFFFFFC},
    '{4'd0, 32'h0, 32'h0, 32'h80000000, 32'h80000000},
    '{4'd0, 32'h0, 32'h0, 32'h7FFFFFFF, 32'h80000000},
    '{4'd1, 32'h0, 32'h0, 32'hFFFFFFFF, 32'hFFFFFFFF},
    '{4'd1, 32'h0, 32'h0, 32'h12345678, 32'h9ABCDEF0},
    '{4'd2, 32'd1, 32'd5, 32'hFFFFFFFE, 32'd3},
    '{4'd3, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'd2, 32'd3},
    '{4'd2, 32'h00000010, 32'hFFFFFFFF, 32'h80000000, 32'h7FFFFFFF},
    '{4'd4, 32'h0, 32'h0, 32'hFFFFFFF9, 32'd2},
    '{4'd4, 32'h0, 32'h0, 32'd7, 32'hFFFFFFFE},
    '{4'd4, 32'h0, 32'h0, 32'd100, 32'd7},
    '{4'd5, 32'h0, 32'h0, 32'hFFFFFFFF, 32'd3},
    '{4'd4, 32'h0, 32'h0, 32'hFFFFFFFB, 32'd0},
    '{4'd5, 32'h0, 32'h0, 32'h00ABCDEF, 32'd0}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [3:0] op = 4'd0;
  logic [31:0] opA = '0, opB = '0;
  logic busy, err, rdValid;
  logic [31:0] rdData;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  mdu_unit uut (
    .clk(clk), .rstN(rstN), .start(start), .op(op), .opA(opA), .opB(opB),
    .busy(busy), .err(err), .rdValid(rdValid), .rdData(rdData)
  );

  function automatic logic [63:0] refCalc(vec_t v);
    logic [63:0] sa, sb, ua, ub;
    logic [31:0] q, r;
    sa = {{32{v.a[31]}}, v.a};
    sb = {{32{v.b[31]}}, v.b};
    ua = {32'h0, v.a};
    ub = {32'h0, v.b};
    case (v.op)
      4'd0: return sa * sb;
      4'd1: return ua * ub;
      4'd2: return {v.ih, v.il} + sa * sb;
      4'd3: return {v.ih, v.il} + ua * ub;
      4'd4: begin
        if (v.b == 0) return {v.a, 32'hFFFFFFFF};
        q = $signed(v.a) / $signed(v.b);
        r = $signed(v.a) % $signed(v.b);
        return {r, q};
      end
      default: begin
        if (v.b == 0) return {v.a, 32'hFFFFFFFF};
        q = v.a / v.b;
        r = v.a % v.b;
        return {r, q};
      end
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [3:0] o, input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    start = 1'b1; op = o; opA = a; opB = b;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic readReg(input logic [3:0] o, output logic [31:0] val, output logic ok);
    issue(o, 32'h0, 32'h0);
    val = rdData;
    ok  = rdValid;
  endtask

  task automatic waitIdle();
    int g = 0;
    while (busy && g < 200) begin
      @(negedge clk);
      g++;
    end
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic ok;
    logic [63:0] exp;
    int n;

    // R9: reset state
    repeat (3) @(negedge clk);
    check(!busy && !err && !rdValid, "R9 flags in reset", {29'd0, busy, err, rdValid}, 32'd0);
    rstN = 1'b1;
    readReg(OP_MFHI, v, ok);
    check(ok && v == 0, "R9 HI after reset", v, 32'd0);
    readReg(OP_MFLO, v, ok);
    check(ok && v == 0, "R9 LO after reset", v, 32'd0);

    // R6: move-to / move-from with a single-cycle valid
    issue(OP_MTHI, 32'hCAFEF00D, 32'h0);
    issue(OP_MTLO, 32'h0BADBEEF, 32'h0);
    readReg(OP_MFHI, v, ok);
    check(ok && v == 32'hCAFEF00D, "R6 move HI", v, 32'hCAFEF00D);
    readReg(OP_MFLO, v, ok);
    check(ok && v == 32'h0BADBEEF, "R6 move LO", v, 32'h0BADBEEF);
    @(negedge clk);
    check(!rdValid, "R6 valid is one cycle", {31'd0, rdValid}, 32'd0);

    // R1 R2 R3 R4: vector table
    for (int i = 0; i < NV; i++) begin
      issue(OP_MTHI, VECS[i].ih, 32'h0);
      issue(OP_MTLO, VECS[i].il, 32'h0);
      issue(VECS[i].op, VECS[i].a, VECS[i].b);
      if (VECS[i].op == 4'd2 || VECS[i].op == 4'd3)
        check(!busy, "R2 madd leaves busy low", {31'd0, busy}, 32'd0);
      else
        waitIdle();
      exp = refCalc(VECS[i]);
      readReg(OP_MFHI, v, ok);
      check(ok && v == exp[63:32],
            VECS[i].op < 2 ? "R1 HI" : VECS[i].op < 4 ? "R2 HI" :
            VECS[i].b == 0 ? "R4 HI" : "R3 HI", v, exp[63:32]);
      readReg(OP_MFLO, v, ok);
      check(ok && v == exp[31:0],
            VECS[i].op < 2 ? "R1 LO" : VECS[i].op < 4 ? "R2 LO" :
            VECS[i].b == 0 ? "R4 LO" : "R3 LO", v, exp[31:0]);
    end

    // R5: busy window length
    issue(OP_DIV, 32'd1000, 32'd3);
    n = 0;
    while (busy && n < 100) begin
      n++;
      @(negedge clk);
    end
    check(n == 32, "R5 busy cycles", n, 32'd32);
    readReg(OP_MFLO, v, ok);
    check(ok && v == 32'd333, "R5 result at busy drop", v, 32'd333);

    // R7: held read answered at completion
    issue(OP_DIVU, 32'd1000, 32'd7);
    issue(OP_MFLO, 32'h0, 32'h0);
    check(!rdValid, "R7 no valid while busy", {31'd0, rdValid}, 32'd0);
    n = 0;
    while (!rdValid && n < 100) begin
      @(negedge clk);
      n++;
    end
    check(rdValid && !busy && rdData == 32'd142, "R7 held read value", rdData, 32'd142);

    // R8: second held read rejected, first still served
    issue(OP_DIV, 32'hFFFFFF9C, 32'd7);
    issue(OP_MFHI, 32'h0, 32'h0);
    issue(OP_MFLO, 32'h0, 32'h0);
    check(err, "R8 second held read flagged", {31'd0, err}, 32'd1);
    n = 0;
    while (!rdValid && n < 100) begin
      @(negedge clk);
      n++;
    end
    check(rdValid && rdData == 32'hFFFFFFFE, "R8 held HI read", rdData, 32'hFFFFFFFE);

    // R8: work op during divide ignored, err is one pulse
    issue(OP_DIV, 32'd50, 32'd5);
    issue(OP_MULT, 32'd3, 32'd3);
    check(err, "R8 err on busy start", {31'd0, err}, 32'd1);
    @(negedge clk);
    check(!err, "R8 err one cycle", {31'd0, err}, 32'd0);
    issue(OP_MTHI, 32'h55555555, 32'h0);
    waitIdle();
    readReg(OP_MFLO, v, ok);
    check(ok && v == 32'd10, "R8 LO kept divide result", v, 32'd10);
    readReg(OP_MFHI, v, ok);
    check(ok && v == 32'd0, "R8 HI kept divide result", v, 32'd0);

    // R10: undefined codes
    issue(OP_MTHI, 32'h00001234, 32'h0);
    issue(OP_MTLO, 32'h00005678, 32'h0);
    for (int c = 10; c < 16; c++) begin
      issue(4'(c), 32'hFFFFFFFF, 32'hFFFFFFFF);
      check(!err && !rdValid && !busy, "R10 no flags", {29'd0, busy, err, rdValid}, 32'd0);
    end
    readReg(OP_MFHI, v, ok);
    check(ok && v == 32'h00001234, "R10 HI unchanged", v, 32'h00001234);
    readReg(OP_MFLO, v, ok);
    check(ok && v == 32'h00005678, "R10 LO unchanged", v, 32'h00005678);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule